// File: doc/BRIEF.md
# Bit-Sliced Integer ALU with Signed Set-Less-Than

This block is a purely combinational integer ALU of parameterised width (32 bits by default). It is organised as a chain of identical one-bit slices. Each slice can optionally complement either operand bit. It then forms the AND, the OR and a full-adder sum of the two bits, and a select picks one of these or a per-slice "less" input. Only the top slice performs overflow detection. From that detection it produces a set bit, which is the true signed sign of the sum. It also drives the final carry.

Subtraction needs no dedicated subtractor: the B-complement control doubles as the carry-in of bit 0, so the adder sees A + ~B + 1. NOR needs no dedicated gate: complementing both operands and selecting AND yields ~A & ~B. Set-less-than works by feeding the top slice's set bit back into the less input of bit 0, while every other slice's less input is 0. A zero flag reports an all-zero result.

Top module: `slice_alu`

## Requirements
- R1: With inv_a=0, inv_b=0 and func=2'b00, res equals opa & opb.
- R2: With inv_a=0, inv_b=0 and func=2'b01, res equals opa | opb.
- R3: With inv_a=0, inv_b=0 and func=2'b10, {cout, res} equals opa + opb as an unsigned sum one bit wider than the operands.
- R4: With inv_a=0, inv_b=1 and func=2'b10, res equals opa - opb modulo 2^W, and cout equals 1 exactly when opa >= opb unsigned.
- R5: With inv_a=0, inv_b=1 and func=2'b11, res[0] is 1 exactly when opa < opb as signed two's-complement values. This holds even when opa - opb overflows, for example the most negative value compared against a positive value.
- R6: With inv_a=1, inv_b=1 and func=2'b00, res equals ~(opa | opb).
- R7: is_zero is 1 exactly when every bit of res is 0, in every mode.
- R8: ovf is 1 exactly when the operands fed to the adder (after optional complement) have equal sign bits and the adder's sum bit W-1 differs from them. This is signed overflow for add and subtract.
- R9: With func=2'b11, bits W-1..1 of res are 0 for every operand value and every complement setting.
- R10: For any inv_a/inv_b setting, the adder computes (inv_a ? ~opa : opa) + (inv_b ? ~opb : opb) + inv_b, and cout is the carry out of bit W-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opa | input | W | First operand |
| opb | input | W | Second operand |
| inv_a | input | 1 | Complement opa before the slices |
| inv_b | input | 1 | Complement opb before the slices; also the carry into bit 0 |
| func | input | 2 | Slice output select: 00 AND, 01 OR, 10 sum, 11 less |
| res | output | W | Result word |
| is_zero | output | 1 | High when res is all zeros |
| ovf | output | 1 | Signed overflow of the adder |
| cout | output | 1 | Carry out of the top slice |

## Verification
Every output is combinational, so each result is due within the same cycle in which its operands and controls are applied. No register delays any of them. The bench changes the inputs just after a rising clock edge and samples all four outputs at the following falling edge, half a period later. Each vector therefore settles fully before it is compared, and none overlaps the next one. Expected values come from a bench function that models the complement, carry-in, sum, overflow and selection rules word-wide, without looking at any slice.

// File: rtl/slice_alu.sv
module slice_alu #(
  parameter int W = 32
) (
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  input  logic         inv_a,
  input  logic         inv_b,
  input  logic [1:0]   func,
  output logic [W-1:0] res,
  output logic         is_zero,
  output logic         ovf,
  output logic         cout
);
  localparam int MSB = W - 1;

  logic [W-1:0] ea, eb, sm, less;
  logic [W:0]   cy;
  logic         set_bit;

  assign ea = inv_a ? ~opa : opa;
  assign eb = inv_b ? ~opb : opb;

  always_comb begin
    cy[0] = inv_b;
    for (int i = 0; i < W; i++) begin
      sm[i]     = ea[i] ^ eb[i] ^ cy[i];
      cy[i + 1] = (ea[i] & eb[i]) | (cy[i] & (ea[i] ^ eb[i]));
    end
  end

  assign ovf     = cy[W] ^ cy[MSB];
  assign cout    = cy[W];
  assign set_bit = sm[MSB] ^ ovf;
  assign less    = {{(W-1){1'b0}}, set_bit};

  genvar g;
  generate
    for (g = 0; g < W; g++) begin : g_slice
      always_comb begin
        unique case (func)
          2'b00:   res[g] = ea[g] & eb[g];
          2'b01:   res[g] = ea[g] | eb[g];
          2'b10:   res[g] = sm[g];
          default: res[g] = less[g];
        endcase
      end
    end
  endgenerate

  assign is_zero = ~|res;

  always_comb begin
    if (!inv_a && !inv_b && func == 2'b10)
      AST_ADD_SUM: assert ({cout, res} == ({1'b0, opa} + {1'b0, opb})); // R3
    if (!inv_a && inv_b && func == 2'b11)
      AST_SLT_SIGNED: assert (res[0] == ($signed(opa) < $signed(opb))); // R5
    if (inv_a && inv_b && func == 2'b00)
      AST_NOR_WORD: assert (res == ~(opa | opb)); // R6
    if (func == 2'b11)
      AST_SLT_UPPER: assert (res[MSB:1] == '0); // R9
    AST_ZERO_FLAG: assert (is_zero == (res == {W{1'b0}})); // R7
  end
endmodule

// File: tb/slice_alu_bench.sv
module slice_alu_bench;
  localparam int W = 32;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic [W-1:0] opa, opb, res;
  logic inv_a, inv_b, is_zero, ovf, cout;
  logic [1:0] func;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  slice_alu #(.W(W)) u_slice_alu (
    .opa(opa), .opb(opb), .inv_a(inv_a), .inv_b(inv_b), .func(func),
    .res(res), .is_zero(is_zero), .ovf(ovf), .cout(cout));

  function automatic logic [W+1:0] model(input logic [W-1:0] a, input logic [W-1:0] b,
                                         input logic ia, input logic ib, input logic [1:0] f);
    logic [W-1:0] x, y, r;
    logic [W:0] s;
    logic v, st;
    x = ia ? ~a : a;
    y = ib ? ~b : b;
    s = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, ib};
    v = (x[W-1] == y[W-1]) && (s[W-1] != x[W-1]);
    st = s[W-1] ^ v;
    case (f)
      2'b00: r = x & y;
      2'b01: r = x | y;
      2'b10: r = s[W-1:0];
      default: r = {{(W-1){1'b0}}, st};
    endcase
    return {s[W], v, r};
  endfunction

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h (a=%h b=%h ia=%0b ib=%0b f=%0d)",
               tag, act, exp, opa, opb, inv_a, inv_b, func);
    end
  endtask

  task automatic apply(input logic [W-1:0] a, input logic [W-1:0] b,
                       input logic ia, input logic ib, input logic [1:0] f, input string tag);
    logic [W+1:0] e;
    @(posedge clk);
    #0.5;
    opa = a; opb = b; inv_a = ia; inv_b = ib; func = f;
    e = model(a, b, ia, ib, f);
    @(negedge clk);
    check(tag, res, e[W-1:0]);
    check("R7 zero", {{(W-1){1'b0}}, is_zero}, {{(W-1){1'b0}}, (e[W-1:0] == '0)});
    check("R8 ovf", {{(W-1){1'b0}}, ovf}, {{(W-1){1'b0}}, e[W]});
    check("R10 cout", {{(W-1){1'b0}}, cout}, {{(W-1){1'b0}}, e[W+1]});
    if (f == 2'b11) check("R9 upper", {res[W-1:1], 1'b0}, '0);
  endtask

  localparam logic [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] MAXV = {1'b0, {(W-1){1'b1}}};

  initial begin
    logic [31:0] seed;
    seed = 32'd7;
    opa = '0; opb = '0; inv_a = 0; inv_b = 0; func = 2'b00;
    @(negedge clk);
    check("R7 initial zero", {{(W-1){1'b0}}, is_zero}, {{(W-1){1'b0}}, 1'b1});
    check("R1 initial res", res, '0);

    apply(32'hF0F0_1234, 32'h0FF0_FFFF, 0, 0, 2'b00, "R1 and");
    apply(32'hF0F0_1234, 32'h0FF0_0000, 0, 0, 2'b01, "R2 or");
    apply(32'hFFFF_FFFF, 32'h0000_0001, 0, 0, 2'b10, "R3 add wrap");
    apply(MAXV, 32'd1, 0, 0, 2'b10, "R3 add ovf");
    apply(MINV, MINV, 0, 0, 2'b10, "R3 add neg ovf");
    apply(32'd5, 32'd5, 0, 1, 2'b10, "R4 sub equal");
    apply(32'd3, 32'd9, 0, 1, 2'b10, "R4 sub borrow");
    apply(MINV, 32'd1, 0, 1, 2'b10, "R4 sub ovf");
    apply(MINV, 32'd1, 0, 1, 2'b11, "R5 slt min vs pos");
    apply(MAXV, 32'hFFFF_FFFF, 0, 1, 2'b11, "R5 slt max vs -1");
    apply(32'hFFFF_FFFF, 32'd0, 0, 1, 2'b11, "R5 slt -1 vs 0");
    apply(32'd7, 32'd7, 0, 1, 2'b11, "R5 slt equal");
    apply(32'd0, 32'd0, 1, 1, 2'b00, "R6 nor zeros");
    apply(32'hA5A5_0F0F, 32'h0101_F000, 1, 1, 2'b00, "R6 nor");
    apply(32'd4, 32'd9, 1, 0, 2'b10, "R10 inv a add");
    apply(32'd4, 32'd9, 1, 0, 2'b11, "R9 slt other inv");

    for (int i = 0; i < 3000; i++) begin
      logic [W-1:0] a, b;
      logic [3:0] k;
      a = $urandom(seed); seed = seed * 32'd69069 + 32'd1;
      b = $urandom(seed); seed = seed * 32'd69069 + 32'd1;
      k = 4'($urandom(seed)); seed = seed * 32'd69069 + 32'd1;
      if (k[3]) b = a ^ (32'd1 << (i % W));
      case (i % 6)
        0: apply(a, b, 0, 0, 2'b00, "R1 rand");
        1: apply(a, b, 0, 0, 2'b01, "R2 rand");
        2: apply(a, b, 0, 0, 2'b10, "R3 rand");
        3: apply(a, b, 0, 1, 2'b10, "R4 rand");
        4: apply(a, b, 0, 1, 2'b11, "R5 rand");
        default: apply(a, b, k[0], k[1], 2'(k[2:1] ^ 2'(i)), "R10 rand");
      endcase
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected done");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule